// File: doc/BRIEF.md
# Priority-Tiered Weighted Round-Robin Arbiter

This block chooses which of ten command ports may pass one command into a shared memory controller in each cycle. Each port carries a 3-bit priority level and a 5-bit static weight. Both come from packed configuration inputs. A separate input holds one 8-bit sum of weights for each of the eight levels. Only the highest level that has a pending request is served. Ports on lower levels wait for as long as any higher-level request is pending.

Inside the winning level, the ports share grants in proportion to their weights. Each port keeps a credit counter, and every grant costs the granted port one credit. When the active weighted requesters of the level have no credit left, every port of that level reloads its credit from its weight. Each level has its own rotation pointer, so the search for the next port starts just after the port that level granted last. A port with weight zero is served only when no active requester of its level has a nonzero weight. A level whose weight sum is zero is served in plain rotation.

The control is a four-state machine. The state records the kind of decision behind the registered grant:
- `ARB_IDLE`: no grant.
- `ARB_CREDIT`: a grant paid from credit.
- `ARB_RELOAD`: a grant made in the same cycle the level reloaded its credits.
- `ARB_EQUAL`: a grant made in plain rotation with credit ignored.

Every state can move to any other. The move is set each cycle by the requests:
- no request → `ARB_IDLE`;
- the winning level is unweighted → `ARB_EQUAL`;
- a weighted requester still holds credit → `ARB_CREDIT`;
- otherwise → `ARB_RELOAD`.

Top module: `tiered_wrr_arbiter`

## Requirements
- R1: After reset the grant vector and the valid output are zero. All credits are zero, and every level's rotation pointer sits on port 9, so the first search of a level starts at port 0.
- R2: The weight of port i is `weight_cfg[5i+4:5i]`. The level of port i is `prio_cfg[3i+2:3i]`. The weight sum of level t is `tier_sum[8t+7:8t]`. A numerically larger level is a higher priority.
- R3: A port is granted only if it requested in the previous cycle and its level is the highest level among all ports requesting in that cycle.
- R4: In a weighted level, the grant goes to the first requesting port after the level's last granted port (wrapping from 9 to 0) that has a nonzero weight and a nonzero credit. That port's credit drops by one.
- R5: When no active nonzero-weight requester of the winning level holds credit, every port of that level loads its credit from its weight in that cycle. The grant is picked among the active nonzero-weight ports, and the picked port is left with its weight minus one. With weights 10, 10 and 5 all requesting for 50 cycles from fresh credit, the ports receive 20, 20 and 10 grants.
- R6: A requesting port with weight zero is never granted while an active requester of its level has a nonzero weight. When all active requesters of the level have weight zero, they are granted in plain rotation.
- R7: If the weight sum of the winning level is zero, that level is served in plain rotation among its requesters, whatever their weights, and credits are left unchanged.
- R8: The grant is one-hot and appears one cycle after the requests that produced it, with valid high. When no port requests, valid and the grant are low in the next cycle.
- R9: Credits and rotation pointers of a level are not touched while that level is not the winning level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 10 | One request bit per port |
| weight_cfg | input | 50 | Packed 5-bit weights, port 0 in the lowest bits |
| prio_cfg | input | 30 | Packed 3-bit levels, port 0 in the lowest bits |
| tier_sum | input | 64 | Packed 8-bit weight sums, level 0 in the lowest bits |
| grant | output | 10 | Registered one-hot grant |
| grant_valid | output | 1 | High when grant holds a port |

## Verification
A stale or wrong credit counter first changes the order of grants. That shows at the grant port within one rotation of the affected level, at most 31 grants per port. By the end of a full reload round it also shifts the per-port grant counts. A wrong rotation pointer shows on the very next grant of that level as a port out of sequence. Disturbed state in a blocked level stays hidden until the higher requests stop. It then appears on the first grant of that level. The bench therefore compares every cycle against an independent model, and it counts grants over whole reload rounds.

// File: rtl/tiered_arb_pkg.sv
package tiered_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_CREDIT = 2'd1,
        ARB_RELOAD = 2'd2,
        ARB_EQUAL  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/tier_select.sv
module tier_select #(
    parameter int NUM_PORTS = 10,
    parameter int P_WIDTH   = 3
) (
    input  logic [NUM_PORTS-1:0]         req,
    input  logic [NUM_PORTS*P_WIDTH-1:0] prio_cfg,
    output logic                         any_req,
    output logic [P_WIDTH-1:0]           top_tier,
    output logic [NUM_PORTS-1:0]         tier_req
);

    always_comb begin
        any_req  = 1'b0;
        top_tier = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req[p] && (!any_req || prio_cfg[p*P_WIDTH +: P_WIDTH] > top_tier)) begin
                top_tier = prio_cfg[p*P_WIDTH +: P_WIDTH];
                any_req  = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_member
        assign tier_req[p] = req[p] && (prio_cfg[p*P_WIDTH +: P_WIDTH] == top_tier);
    end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        int p;
        found = 1'b0;
        idx   = last;
        p     = 0;
        for (int k = 1; k <= N; k++) begin
            p = (int'(last) + k) % N;
            if (!found && mask[p]) begin
                found = 1'b1;
                idx   = IW'(p);
            end
        end
    end

endmodule

// File: rtl/tiered_wrr_arbiter.sv
module tiered_wrr_arbiter
    import tiered_arb_pkg::*;
#(
    parameter int NUM_PORTS = 10,
    parameter int W_WIDTH   = 5,
    parameter int P_WIDTH   = 3,
    parameter int S_WIDTH   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_PORTS-1:0]                req,
    input  logic [NUM_PORTS*W_WIDTH-1:0]        weight_cfg,
    input  logic [NUM_PORTS*P_WIDTH-1:0]        prio_cfg,
    input  logic [(1<<P_WIDTH)*S_WIDTH-1:0]     tier_sum,
    output logic [NUM_PORTS-1:0]                grant,
    output logic                                grant_valid
);

    localparam int NUM_TIERS = 1 << P_WIDTH;
    localparam int IW        = $clog2(NUM_PORTS);

    arb_state_e             state_q, next_state;
    logic [W_WIDTH-1:0]     credit_q [NUM_PORTS];
    logic [IW-1:0]          last_q   [NUM_TIERS];
    logic [NUM_PORTS-1:0]   grant_q;

    logic [W_WIDTH-1:0]     weight_a [NUM_PORTS];
    logic [P_WIDTH-1:0]     level_a  [NUM_PORTS];
    logic [NUM_PORTS-1:0]   weight_nz, credit_nz;

    logic                   any_req;
    logic [P_WIDTH-1:0]     top_tier;
    logic [NUM_PORTS-1:0]   tier_req;
    logic [NUM_PORTS-1:0]   act_weighted, eligible, pick_mask;
    logic                   sum_nz, weighted_tier;
    logic                   pick_found;
    logic [IW-1:0]          pick_idx;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
        assign weight_a[p]  = weight_cfg[p*W_WIDTH +: W_WIDTH];
        assign level_a[p]   = prio_cfg[p*P_WIDTH +: P_WIDTH];
        assign weight_nz[p] = (weight_a[p] != '0);
        assign credit_nz[p] = (credit_q[p] != '0);
    end

    tier_select #(
        .NUM_PORTS (NUM_PORTS),
        .P_WIDTH   (P_WIDTH)
    ) u_tier (
        .req      (req),
        .prio_cfg (prio_cfg),
        .any_req  (any_req),
        .top_tier (top_tier),
        .tier_req (tier_req)
    );

    assign sum_nz        = (tier_sum[top_tier*S_WIDTH +: S_WIDTH] != '0);
    assign act_weighted  = tier_req & weight_nz;
    assign weighted_tier = sum_nz && (act_weighted != '0);
    assign eligible      = act_weighted & credit_nz;

    // decision for this cycle
    always_comb begin
        if (!any_req)
            next_state = ARB_IDLE;
        else if (!weighted_tier)
            next_state = ARB_EQUAL;
        else if (eligible != '0)
            next_state = ARB_CREDIT;
        else
            next_state = ARB_RELOAD;
    end

    always_comb begin
        unique case (next_state)
            ARB_IDLE:   pick_mask = '0;
            ARB_CREDIT: pick_mask = eligible;
            ARB_RELOAD: pick_mask = act_weighted;
            ARB_EQUAL:  pick_mask = tier_req;
            default:    pick_mask = '0;
        endcase
    end

    rr_pick #(
        .N  (NUM_PORTS),
        .IW (IW)
    ) u_pick (
        .mask  (pick_mask),
        .last  (last_q[top_tier]),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ARB_IDLE;
        else
            state_q <= next_state;
    end

    // grant, credits and rotation pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            for (int p = 0; p < NUM_PORTS; p++) credit_q[p] <= '0;
            for (int t = 0; t < NUM_TIERS; t++) last_q[t] <= IW'(NUM_PORTS - 1);
        end else begin
            grant_q <= '0;
            unique case (next_state)
                ARB_CREDIT: credit_q[pick_idx] <= credit_q[pick_idx] - W_WIDTH'(1);
                ARB_RELOAD: begin
                    for (int p = 0; p < NUM_PORTS; p++) begin
                        if (level_a[p] == top_tier)
                            credit_q[p] <= (IW'(p) == pick_idx) ? weight_a[p] - W_WIDTH'(1)
                                                                : weight_a[p];
                    end
                end
                ARB_IDLE, ARB_EQUAL: ;
                default: ;
            endcase
            if (next_state != ARB_IDLE && pick_found) begin
                grant_q[pick_idx] <= 1'b1;
                last_q[top_tier]  <= pick_idx;
            end
        end
    end

    assign grant       = grant_q;
    assign grant_valid = (state_q != ARB_IDLE);

    function automatic logic [P_WIDTH-1:0] granted_level(
        input logic [NUM_PORTS-1:0]         g,
        input logic [NUM_PORTS*P_WIDTH-1:0] cfg
    );
        granted_level = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (g[p]) granted_level = cfg[p*P_WIDTH +: P_WIDTH];
    endfunction

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant) == 1));

    // R8
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant == '0));

    // R8
    request_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |=> grant_valid);

    // R8
    no_request_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> !grant_valid);

    // R3
    granted_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |=> ((grant & $past(req)) != '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tier_chk
        // R3
        strict_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req[p] |=> (granted_level(grant, $past(prio_cfg))
                        >= $past(prio_cfg[p*P_WIDTH +: P_WIDTH])));
    end

endmodule

// File: tb/tiered_wrr_arbiter_test.sv
`timescale 1ns/1ps
module tiered_wrr_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  req = '0;
    logic [49:0] weight_cfg = '0;
    logic [29:0] prio_cfg = '0;
    logic [63:0] tier_sum = '0;
    logic [9:0]  grant;
    logic        grant_valid;

    always #4 clk = ~clk;

    tiered_wrr_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req(req), .weight_cfg(weight_cfg),
        .prio_cfg(prio_cfg), .tier_sum(tier_sum), .grant(grant),
        .grant_valid(grant_valid)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench-side configuration and reference state
    int w [10];
    int lv[10];
    int sm[8];
    int cr[10];
    int lp[8];
    int tally[10];
    int base[10];

    typedef struct {
        logic [9:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pack_cfg();
        for (int p = 0; p < 10; p++) begin
            weight_cfg[p*5 +: 5] = 5'(w[p]);
            prio_cfg[p*3 +: 3]   = 3'(lv[p]);
        end
        for (int t = 0; t < 8; t++) tier_sum[t*8 +: 8] = 8'(sm[t]);
    endtask

    task automatic apply_cfg();
        @(posedge clk);
        #2;
        pack_cfg();
    endtask

    task automatic model(input logic [9:0] r, output logic [9:0] g);
        int top, pick;
        bit anyw, anyc;
        top = -1; pick = -1; anyw = 0; anyc = 0; g = '0;
        for (int p = 0; p < 10; p++) if (r[p] && lv[p] > top) top = lv[p];
        if (top >= 0) begin
            for (int p = 0; p < 10; p++)
                if (r[p] && lv[p] == top && w[p] > 0) begin
                    anyw = 1;
                    if (cr[p] > 0) anyc = 1;
                end
            if (sm[top] == 0) anyw = 0;
            for (int k = 1; k <= 10; k++) begin
                int p;
                p = (lp[top] + k) % 10;
                if (pick < 0 && r[p] && lv[p] == top &&
                    (!anyw || (w[p] > 0 && (!anyc || cr[p] > 0))))
                    pick = p;
            end
            if (anyw) begin
                if (!anyc)
                    for (int q = 0; q < 10; q++) if (lv[q] == top) cr[q] = w[q];
                cr[pick] = cr[pick] - 1;
            end
            lp[top] = pick;
            g[pick] = 1'b1;
        end
    endtask

    task automatic run(input logic [9:0] r, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            @(negedge clk);
            req = r;
            model(r, it.exp);
            it.tag = tag;
            sb.push_back(it);
        end
    endtask

    task automatic settle();
        run('0, 1, "R8 idle");
        @(posedge clk);
        #3;
    endtask

    task automatic snap();
        for (int p = 0; p < 10; p++) base[p] = tally[p];
    endtask

    function automatic int got(input int p);
        return tally[p] - base[p];
    endfunction

    // monitor
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " grant"}, 32'(grant), 32'(it.exp));
            check({it.tag, " valid"}, 32'(grant_valid), 32'(it.exp != '0));
            for (int p = 0; p < 10; p++) if (grant[p]) tally[p]++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 10; p++) begin
            w[p] = 0; lv[p] = 0; cr[p] = 0; tally[p] = 0; base[p] = 0;
        end
        for (int t = 0; t < 8; t++) begin
            sm[t] = 0; lp[t] = 9;
        end
        // R2: ports 0..2 on level 1 with weights 10,10,5; 6..9 on level 0
        w[0] = 10; w[1] = 10; w[2] = 5; lv[0] = 1; lv[1] = 1; lv[2] = 1;
        w[6] = 1; w[7] = 4; w[8] = 1; w[9] = 4;
        sm[1] = 25; sm[0] = 10;
        pack_cfg();

        repeat (3) @(posedge clk);
        #1;
        // R1
        check("R1 reset grant", 32'(grant), 32'h0);
        check("R1 reset valid", 32'(grant_valid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 R3: level 1 shares 20/20/10 and level 0 is fully blocked
        snap();
        run(10'b11_1100_0111, 50, "R5 R3 weighted share");
        settle();
        check("R5 port0 share", 32'(got(0)), 32'd20);
        check("R5 port1 share", 32'(got(1)), 32'd20);
        check("R5 port2 share", 32'(got(2)), 32'd10);
        check("R3 lower tier blocked", 32'(got(6) + got(7) + got(8) + got(9)), 32'd0);

        // R4 R9: level 0 alone, its credits untouched while blocked
        snap();
        run(10'b11_1100_0000, 20, "R4 R9 lower tier");
        settle();
        check("R9 port6 share", 32'(got(6)), 32'd2);
        check("R9 port7 share", 32'(got(7)), 32'd8);
        check("R4 port8 share", 32'(got(8)), 32'd2);
        check("R4 port9 share", 32'(got(9)), 32'd8);

        // R6: zero-weight ports on level 3
        lv[3] = 3; lv[4] = 3; lv[5] = 3; w[3] = 0; w[4] = 0; w[5] = 3; sm[3] = 3;
        apply_cfg();
        snap();
        run(10'b00_0011_1000, 6, "R6 weighted beats zero");
        settle();
        check("R6 port5 only", 32'(got(5)), 32'd6);
        check("R6 zero ports held", 32'(got(3) + got(4)), 32'd0);
        snap();
        run(10'b00_0001_1000, 4, "R6 zero rotation");
        settle();
        check("R6 port3 rotation", 32'(got(3)), 32'd2);
        check("R6 port4 rotation", 32'(got(4)), 32'd2);

        // R7: zero level sum gives plain rotation
        sm[3] = 0;
        apply_cfg();
        snap();
        run(10'b00_0011_1000, 6, "R7 plain rotation");
        settle();
        check("R7 port3", 32'(got(3)), 32'd2);
        check("R7 port4", 32'(got(4)), 32'd2);
        check("R7 port5", 32'(got(5)), 32'd2);

        // R3 R8: top level port pre-empts at once, one-cycle latency
        lv[4] = 7;
        apply_cfg();
        snap();
        run(10'b00_0001_0011, 5, "R3 R8 top level");
        settle();
        check("R3 port4 wins", 32'(got(4)), 32'd5);
        check("R8 others idle", 32'(got(0) + got(1)), 32'd0);

        @(negedge clk);
        req = 10'b00_0010_0000;
        #1;
        check("R8 latency before edge", 32'(grant_valid), 32'd0);
        model(req, sb[0].exp);
        @(posedge clk);
        #1;
        check("R8 latency after edge", 32'(grant), 32'h020);
        sb.delete();
        run('0, 3, "R8 no request");
        settle();
        check("R8 idle valid", 32'(grant_valid), 32'd0);

        finish_run();
    end

endmodule